// File: doc/BRIEF.md
# Security Attribution Address Checker

This block gives every bus request a security label and decides whether the request may proceed. A few programmable address windows, each with an inclusive base and limit at 32-byte granularity, mark parts of the map as Non-secure or as Non-secure-callable. Any address outside every enabled window is Secure. A per-request label from system-level logic, such as a flash-page or peripheral map, is combined with the window result, and the more secure of the two is used.

Each request states the security state of its requester, whether it comes from the core or from the debugger, whether it is a branch, and whether the branch target holds the gateway instruction. The block returns, one cycle after the request strobe, the resolved label, the non-secure tag to drive on the downstream bus, and a fault flag. Non-secure code may enter secure memory only by branching onto a gateway instruction that sits in Non-secure-callable memory. Debugger traffic passes through the same check and is always treated as a data access.

Top module: `sec_attr_checker`

## Requirements
- R1: After reset, rsp_valid, rsp_fault and rsp_ns are 0, rsp_attr is Secure (2), and every window is disabled, so any address resolves to Secure.
- R2: rsp_valid is 1 in exactly the cycle after a cycle with req_valid high, and 0 otherwise. The response describes the request of that earlier cycle.
- R3: An address that lies in no enabled window resolves to Secure. Window bounds are inclusive and compared on address bits [31:5].
- R4: A hit on an enabled window yields Non-secure (cfg_nsc=0) or Non-secure-callable (cfg_nsc=1). When windows overlap, the one with the lowest index decides.
- R5: Label encoding is 0 = Non-secure, 1 = Non-secure-callable, 2 = Secure, and an ext_attr value of 3 counts as Secure. The resolved label is the higher-ranked of the window result and ext_attr, where Secure ranks above Non-secure-callable, which ranks above Non-secure.
- R6: A data access from a non-secure requester faults when the label is Secure or Non-secure-callable. It does not fault when the label is Non-secure.
- R7: A non-secure requester always gets rsp_ns=1. A secure requester gets rsp_ns=1 only when the label is Non-secure.
- R8: A non-secure branch to a Non-secure-callable target is allowed when req_gateway=1 and faults when req_gateway=0.
- R9: A non-secure branch to a Secure target faults, even when req_gateway=1. A non-secure branch to a Non-secure target does not fault.
- R10: A request from a secure requester never faults.
- R11: For debugger requests (req_dbg=1), req_branch and req_gateway are ignored and the data-access rule applies.
- R12: A disabled window has no effect. A window write takes effect for a request presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for one window |
| cfg_sel | input | 2 | Index of the window to write |
| cfg_base | input | 27 | Lowest granule of the window (address bits [31:5]) |
| cfg_limit | input | 27 | Highest granule of the window, inclusive |
| cfg_enable | input | 1 | Window enable |
| cfg_nsc | input | 1 | 1 = Non-secure-callable window, 0 = Non-secure window |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_secure | input | 1 | Requester is in secure state |
| req_dbg | input | 1 | Requester is the debugger |
| req_branch | input | 1 | Request is a control-flow transfer to req_addr |
| req_gateway | input | 1 | Branch target holds the gateway instruction |
| ext_attr | input | 2 | System-level label for req_addr |
| rsp_valid | output | 1 | Response valid |
| rsp_attr | output | 2 | Resolved label |
| rsp_ns | output | 1 | Non-secure tag for the downstream bus |
| rsp_fault | output | 1 | Security fault |

## Verification
A corrupted window register shows up at the ports on the first request that falls into that window after the corruption. The wrong label appears on rsp_attr one cycle later, usually together with a fault that should not be there or a missing one. Errors in the window priority or in the merge with ext_attr show up only for requests that fall where windows overlap or where the external label disagrees, so the stimulus is aimed at exactly those addresses. A slip in the output register becomes visible within one cycle as a response that belongs to the wrong request.

// File: rtl/sac_pkg.sv
package sac_pkg;
  typedef enum logic [1:0] {
    ATTR_NS  = 2'd0,
    ATTR_NSC = 2'd1,
    ATTR_S   = 2'd2
  } attr_e;

  // anything outside the defined codes is treated as the strongest label
  function automatic attr_e attr_norm(input logic [1:0] code);
    case (code)
      2'd0:    return ATTR_NS;
      2'd1:    return ATTR_NSC;
      default: return ATTR_S;
    endcase
  endfunction

  function automatic attr_e attr_stronger(input attr_e a, input attr_e b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sac_region_file.sv
module sac_region_file
  import sac_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GRAN_W      = 5,
  parameter int NUM_REGIONS = 4,
  parameter int SEL_W       = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_wr,
  input  logic [SEL_W-1:0]         cfg_sel,
  input  logic [ADDR_W-GRAN_W-1:0] cfg_base,
  input  logic [ADDR_W-GRAN_W-1:0] cfg_limit,
  input  logic                     cfg_enable,
  input  logic                     cfg_nsc,
  input  logic [ADDR_W-1:0]        lookup_addr,
  output attr_e                    int_attr
);
  localparam int PAGE_W = ADDR_W - GRAN_W;

  logic [PAGE_W-1:0]      base_q  [NUM_REGIONS];
  logic [PAGE_W-1:0]      limit_q [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] en_q;
  logic [NUM_REGIONS-1:0] nsc_q;
  logic [NUM_REGIONS-1:0] hit;
  logic [PAGE_W-1:0]      page;

  assign page = lookup_addr[ADDR_W-1:GRAN_W];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
        en_q[g]    <= 1'b0;
        nsc_q[g]   <= 1'b0;
      end else if (cfg_wr && (int'(cfg_sel) == g)) begin
        base_q[g]  <= cfg_base;
        limit_q[g] <= cfg_limit;
        en_q[g]    <= cfg_enable;
        nsc_q[g]   <= cfg_nsc;
      end
    end

    assign hit[g] = en_q[g] && (page >= base_q[g]) && (page <= limit_q[g]);
  end

  // walk downwards so the lowest matching index is the last one written
  always_comb begin
    int_attr = ATTR_S;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit[i]) int_attr = nsc_q[i] ? ATTR_NSC : ATTR_NS;
    end
  end
endmodule

// File: rtl/sac_policy.sv
module sac_policy
  import sac_pkg::*;
(
  input  attr_e final_attr,
  input  logic  req_secure,
  input  logic  req_dbg,
  input  logic  req_branch,
  input  logic  req_gateway,
  output logic  ns_tag,
  output logic  fault
);
  logic is_branch;

  assign is_branch = req_branch && !req_dbg;

  always_comb begin
    if (req_secure) begin
      ns_tag = (final_attr == ATTR_NS);
      fault  = 1'b0;
    end else begin
      ns_tag = 1'b1;
      if (is_branch) begin
        fault = (final_attr == ATTR_S) ||
                ((final_attr == ATTR_NSC) && !req_gateway);
      end else begin
        fault = (final_attr != ATTR_NS);
      end
    end
  end
endmodule

// File: rtl/sec_attr_checker.sv
module sec_attr_checker
  import sac_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int GRAN_W      = 5,
  parameter int NUM_REGIONS = 4,
  localparam int SEL_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int PAGE_W     = ADDR_W - GRAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [PAGE_W-1:0] cfg_base,
  input  logic [PAGE_W-1:0] cfg_limit,
  input  logic              cfg_enable,
  input  logic              cfg_nsc,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_secure,
  input  logic              req_dbg,
  input  logic              req_branch,
  input  logic              req_gateway,
  input  logic [1:0]        ext_attr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_attr,
  output logic              rsp_ns,
  output logic              rsp_fault
);
  attr_e int_attr;
  attr_e final_attr;
  logic  ns_tag;
  logic  fault;

  sac_region_file #(
    .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .NUM_REGIONS(NUM_REGIONS), .SEL_W(SEL_W)
  ) u_regions (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_base(cfg_base),
    .cfg_limit(cfg_limit), .cfg_enable(cfg_enable), .cfg_nsc(cfg_nsc),
    .lookup_addr(req_addr), .int_attr(int_attr)
  );

  assign final_attr = attr_stronger(int_attr, attr_norm(ext_attr));

  sac_policy u_policy (
    .final_attr(final_attr), .req_secure(req_secure), .req_dbg(req_dbg),
    .req_branch(req_branch), .req_gateway(req_gateway),
    .ns_tag(ns_tag), .fault(fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_attr  <= ATTR_S;
      rsp_ns    <= 1'b0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_attr  <= final_attr;
        rsp_ns    <= ns_tag;
        rsp_fault <= fault;
      end
    end
  end
endmodule

// File: rtl/sac_checker.sv
module sac_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_secure,
  input logic       rsp_valid,
  input logic [1:0] rsp_attr,
  input logic       rsp_ns,
  input logic       rsp_fault
);
  assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  assert_nonsecure_tagged_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_secure) |=> rsp_ns);

  assert_secure_never_faults_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_secure) |=> !rsp_fault);

  assert_ns_to_secure_faults_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_secure) |=> (rsp_attr != 2'd2 || rsp_fault));

  assert_label_legal_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_attr != 2'd3);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!rsp_valid && !rsp_fault));
endmodule

bind sec_attr_checker sac_checker u_sac_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_secure(req_secure),
  .rsp_valid(rsp_valid), .rsp_attr(rsp_attr), .rsp_ns(rsp_ns),
  .rsp_fault(rsp_fault)
);

// File: tb/test_sec_attr_checker.sv
module test_sec_attr_checker;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [1:0]  cfg_sel;
  logic [26:0] cfg_base;
  logic [26:0] cfg_limit;
  logic        cfg_enable;
  logic        cfg_nsc;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        req_secure;
  logic        req_dbg;
  logic        req_branch;
  logic        req_gateway;
  logic [1:0]  ext_attr;
  logic        rsp_valid;
  logic [1:0]  rsp_attr;
  logic        rsp_ns;
  logic        rsp_fault;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sec_attr_checker i_sec_attr_checker (.*);

  // {id[3:0], addr[31:0], sec, dbg, br, gw, ext[1:0], exp_attr[1:0], exp_ns, exp_fault}
  localparam int NV = 20;
  localparam logic [45:0] VEC [NV] = '{
    {4'd6,  32'h1000_0010, 4'b0000, 2'd0, 2'd0, 1'b1, 1'b0}, // R6 NS data to NS
    {4'd3,  32'h1000_FFFC, 4'b0000, 2'd0, 2'd0, 1'b1, 1'b0}, // R3 inclusive limit
    {4'd3,  32'h1001_0000, 4'b0000, 2'd0, 2'd2, 1'b1, 1'b1}, // R3 past limit
    {4'd3,  32'h0FFF_FFFC, 4'b0000, 2'd0, 2'd2, 1'b1, 1'b1}, // R3 below base
    {4'd6,  32'h2000_0100, 4'b0000, 2'd0, 2'd1, 1'b1, 1'b1}, // R6 NS data to NSC
    {4'd8,  32'h2000_0100, 4'b0011, 2'd0, 2'd1, 1'b1, 1'b0}, // R8 gateway ok
    {4'd8,  32'h2000_0100, 4'b0010, 2'd0, 2'd1, 1'b1, 1'b1}, // R8 no gateway
    {4'd9,  32'h4000_0000, 4'b0011, 2'd0, 2'd2, 1'b1, 1'b1}, // R9 gateway in S
    {4'd9,  32'h1000_0200, 4'b0010, 2'd0, 2'd0, 1'b1, 1'b0}, // R9 branch to NS
    {4'd7,  32'h4000_0000, 4'b1000, 2'd0, 2'd2, 1'b0, 1'b0}, // R7 secure to S
    {4'd7,  32'h1000_0200, 4'b1000, 2'd0, 2'd0, 1'b1, 1'b0}, // R7 secure to NS
    {4'd10, 32'h2000_0100, 4'b1010, 2'd0, 2'd1, 1'b0, 1'b0}, // R10 secure branch
    {4'd4,  32'h1000_8040, 4'b0000, 2'd0, 2'd0, 1'b1, 1'b0}, // R4 overlap, low index
    {4'd5,  32'h1000_0200, 4'b0000, 2'd1, 2'd1, 1'b1, 1'b1}, // R5 ext raises to NSC
    {4'd5,  32'h1000_0200, 4'b1000, 2'd2, 2'd2, 1'b0, 1'b0}, // R5 ext raises to S
    {4'd5,  32'h2000_0100, 4'b0011, 2'd0, 2'd1, 1'b1, 1'b0}, // R5 internal stronger
    {4'd5,  32'h2000_0100, 4'b0011, 2'd3, 2'd2, 1'b1, 1'b1}, // R5 code 3 is S
    {4'd11, 32'h2000_0100, 4'b0111, 2'd0, 2'd1, 1'b1, 1'b1}, // R11 debugger branch
    {4'd11, 32'h1000_0200, 4'b0110, 2'd0, 2'd0, 1'b1, 1'b0}, // R11 debugger to NS
    {4'd12, 32'h3000_0100, 4'b0000, 2'd0, 2'd2, 1'b1, 1'b1}  // R12 disabled window
  };

  task automatic check(input string rq, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic write_win(input logic [1:0] sel, input logic [31:0] lo,
                           input logic [31:0] hi, input logic en, input logic nsc);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_base = lo[31:5]; cfg_limit = hi[31:5];
    cfg_enable = en; cfg_nsc = nsc;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // drives one request on a falling edge; the response is registered on the
  // next rising edge and sampled on the falling edge after that
  task automatic send(input logic [31:0] a, input logic [3:0] flags, input logic [1:0] ext);
    req_valid = 1'b1; req_addr = a;
    {req_secure, req_dbg, req_branch, req_gateway} = flags;
    ext_attr = ext;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string rq, input logic [1:0] ea, input logic ens,
                            input logic ef);
    check(rq, "valid", 32'(rsp_valid), 32'd1);
    check(rq, "attr",  32'(rsp_attr),  32'(ea));
    check(rq, "ns",    32'(rsp_ns),    32'(ens));
    check(rq, "fault", 32'(rsp_fault), 32'(ef));
  endtask

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_sel = '0; cfg_base = '0; cfg_limit = '0;
    cfg_enable = 1'b0; cfg_nsc = 1'b0; req_valid = 1'b0; req_addr = '0;
    req_secure = 1'b0; req_dbg = 1'b0; req_branch = 1'b0; req_gateway = 1'b0;
    ext_attr = 2'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "valid", 32'(rsp_valid), 32'd0);
    check("R1", "attr",  32'(rsp_attr),  32'd2);
    check("R1", "ns",    32'(rsp_ns),    32'd0);
    check("R1", "fault", 32'(rsp_fault), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // R1 with no windows, a usually non-secure address is Secure
    send(32'h1000_0010, 4'b0000, 2'd0);
    expect_rsp("R1", 2'd2, 1'b1, 1'b1);

    write_win(2'd0, 32'h1000_0000, 32'h1000_FFE0, 1'b1, 1'b0);
    write_win(2'd1, 32'h2000_0000, 32'h2000_03E0, 1'b1, 1'b1);
    write_win(2'd2, 32'h1000_8000, 32'h1000_80E0, 1'b1, 1'b1);
    write_win(2'd3, 32'h3000_0000, 32'h3000_0FE0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      automatic logic [45:0] v = VEC[i];
      automatic string rq = $sformatf("R%0d", v[45:42]);
      @(negedge clk);
      send(v[41:10], v[9:6], v[5:4]);
      expect_rsp(rq, v[3:2], v[1], v[0]);
    end

    // R2 no response without a request
    @(negedge clk);
    check("R2", "idle valid", 32'(rsp_valid), 32'd0);

    // R2 back-to-back requests each answered in order
    req_valid = 1'b1; req_addr = 32'h4000_0000;
    {req_secure, req_dbg, req_branch, req_gateway} = 4'b0000; ext_attr = 2'd0;
    @(negedge clk);
    expect_rsp("R2", 2'd2, 1'b1, 1'b1);
    req_addr = 32'h1000_0040;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp("R2", 2'd0, 1'b1, 1'b0);

    // R12 enable window 3, request in the very next cycle
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = 2'd3; cfg_base = 27'(32'h3000_0000 >> 5);
    cfg_limit = 27'(32'h3000_0FE0 >> 5); cfg_enable = 1'b1; cfg_nsc = 1'b0;
    @(negedge clk);
    cfg_wr = 1'b0;
    send(32'h3000_0100, 4'b0000, 2'd0);
    expect_rsp("R12", 2'd0, 1'b1, 1'b0);

    // R4 window 0 disabled: overlap area now falls to window 2 (NSC)
    write_win(2'd0, 32'h1000_0000, 32'h1000_FFE0, 1'b0, 1'b0);
    send(32'h1000_8040, 4'b0011, 2'd0);
    expect_rsp("R4", 2'd1, 1'b1, 1'b0);

    // R1 reset clears windows again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    send(32'h2000_0100, 4'b0011, 2'd0);
    expect_rsp("R1", 2'd2, 1'b1, 1'b1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule